// File: doc/BRIEF.md
# Posted-CAS Additive Latency Scheduler

This block models, on the device side, how a DDR2-style memory times posted column commands. It accepts a READ or WRITE on a command strobe and holds it for a programmable additive latency (AL). It then issues the command internally, which lets a controller send the column command before the row-to-column delay has elapsed. After that it marks the clock periods in which read data must start to leave the device and write data must start to arrive.

AL comes from a 3-bit field in an extended-mode-register load word. The CAS latency (CL) is a static input. Read latency is RL = AL + CL and write latency is WL = RL - 1. A reserved AL code is refused: the previous setting is kept and a sticky error flag is raised. Pending commands travel down a shift register that is deep enough for the largest AL plus the largest CL, so a command accepted on every cycle is tracked on its own.

Timing convention: a command is presented during clock period p and sampled at the rising edge that ends that period. An event that is N cycles later is high during period p + N, so N = 0 means the same period.

Top module: `al_sched`

## Requirements
- R1: On `emr_load_i`, the AL code is taken from `emr_i[5:3]`. All other bits of `emr_i` have no effect on `al_o`, the error flag or the timing.
- R2: A loaded code from 0 to 6 becomes `al_o` in the period after the load.
- R3: A loaded code of 7 is reserved. `al_o` keeps its previous value, and `cfg_err_o` rises in the next period and stays high until reset.
- R4: A command presented in period p produces `int_cmd_valid_o` in period p + AL, with `int_cmd_is_wr_o` equal to the command's type. When AL = 0 this happens in period p itself.
- R5: A READ in period p produces a one-period `rd_data_start_o` in period p + AL + CL.
- R6: A WRITE in period p produces a one-period `wr_data_start_o` in period p + AL + CL - 1.
- R7: Commands presented in consecutive periods each produce their own pulses at their own latencies, including a read start and a write start in the same period.
- R8: While `rst_ni` is low, `al_o` is 0, `cfg_err_o` is 0 and all pending commands are discarded, so no pulse caused by a command from before the reset appears afterwards.
- R9: `cmd_is_wr_i` = 1 marks a WRITE and 0 marks a READ. A READ never pulses `wr_data_start_o`, and a WRITE never pulses `rd_data_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emr_load_i | input | 1 | Load strobe for the extended mode word |
| emr_i | input | 14 | Extended mode word; AL code in bits 5:3 |
| cl_i | input | 3 | Static CAS latency, 2 to CL_MAX |
| cmd_valid_i | input | 1 | Column command strobe |
| cmd_is_wr_i | input | 1 | 1 = WRITE, 0 = READ |
| al_o | output | 3 | Active additive latency |
| cfg_err_o | output | 1 | Sticky reserved-code flag |
| int_cmd_valid_o | output | 1 | Command issued internally after AL |
| int_cmd_is_wr_o | output | 1 | Type of the internally issued command |
| rd_data_start_o | output | 1 | First read data period (RL) |
| wr_data_start_o | output | 1 | First write data period (WL) |

## Verification
The assertions rely on two conditions at the inputs. `cl_i` stays fixed and legal while any command is in flight, and `emr_load_i` comes only when no command is pending, so the latency taps never move under a command. The stimulus keeps to both. It changes CL and loads new AL codes only after idle periods longer than the deepest latency. It also holds the command strobe low while reset is asserted. The sweep covers every CL from 2 to 6 and every AL code, including the reserved one, under dense, alternating and sparse command patterns.

// File: rtl/al_sched_pkg.sv
package al_sched_pkg;
  localparam int AL_W = 3;
  localparam logic [AL_W-1:0] AL_RESERVED = 3'd7;

  typedef struct packed {
    logic vld;
    logic is_wr;
  } cmd_t;
endpackage

// File: rtl/al_cfg.sv
module al_cfg
  import al_sched_pkg::*;
#(
  parameter int EMR_W  = 14,
  parameter int AL_LSB = 3,
  parameter int AL_MAX = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [EMR_W-1:0] emr_i,
  output logic [AL_W-1:0]  al_o,
  output logic             err_o
);
  logic [AL_W-1:0] code;
  logic            reserved;

  assign code     = emr_i[AL_LSB +: AL_W];
  assign reserved = (code == AL_RESERVED) || (int'(code) > AL_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al_o  <= '0;
      err_o <= 1'b0;
    end else if (load_i) begin
      if (reserved) err_o <= 1'b1;
      else          al_o  <= code;
    end
  end

  p_al_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(al_o) <= AL_MAX);
  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_reserved_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && reserved) |=> ($stable(al_o) && err_o));
endmodule

// File: rtl/al_pipe.sv
module al_pipe
  import al_sched_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_t             cmd_i,
  output logic [DEPTH-1:0] vld_o,
  output logic [DEPTH-1:0] wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= '0;
      wr_o  <= '0;
    end else begin
      vld_o <= {vld_o[DEPTH-2:0], cmd_i.vld};
      wr_o  <= {wr_o[DEPTH-2:0],  cmd_i.vld & cmd_i.is_wr};
    end
  end
endmodule

// File: rtl/al_tap.sv
module al_tap
  import al_sched_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH:0]   vld_i,
  input  logic [DEPTH:0]   wr_i,
  input  logic [IDX_W-1:0] idx_i,
  output cmd_t             cmd_o
);
  always_comb begin
    cmd_o = '0;
    if (int'(idx_i) <= DEPTH) begin
      cmd_o.vld   = vld_i[idx_i];
      cmd_o.is_wr = wr_i[idx_i];
    end
  end
endmodule

// File: rtl/al_sched.sv
module al_sched
  import al_sched_pkg::*;
#(
  parameter int EMR_W  = 14,
  parameter int AL_LSB = 3,
  parameter int AL_MAX = 6,
  parameter int CL_W   = 3,
  parameter int CL_MAX = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emr_load_i,
  input  logic [EMR_W-1:0] emr_i,
  input  logic [CL_W-1:0]  cl_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_is_wr_i,
  output logic [AL_W-1:0]  al_o,
  output logic             cfg_err_o,
  output logic             int_cmd_valid_o,
  output logic             int_cmd_is_wr_o,
  output logic             rd_data_start_o,
  output logic             wr_data_start_o
);
  localparam int DEPTH = AL_MAX + CL_MAX;
  localparam int IDX_W = $clog2(DEPTH + 2);

  cmd_t             cmd_in, al_cmd, rl_cmd, wl_cmd;
  logic [DEPTH-1:0] pipe_vld, pipe_wr;
  logic [DEPTH:0]   chain_vld, chain_wr;
  logic [IDX_W-1:0] al_idx, rl_idx, wl_idx;

  al_cfg #(.EMR_W(EMR_W), .AL_LSB(AL_LSB), .AL_MAX(AL_MAX)) u_cfg (
    .clk_i, .rst_ni, .load_i(emr_load_i), .emr_i,
    .al_o, .err_o(cfg_err_o)
  );

  assign cmd_in.vld   = cmd_valid_i;
  assign cmd_in.is_wr = cmd_is_wr_i;

  al_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk_i, .rst_ni, .cmd_i(cmd_in), .vld_o(pipe_vld), .wr_o(pipe_wr)
  );

  // tap 0 is the live command, tap n is n cycles old
  assign chain_vld = {pipe_vld, cmd_valid_i};
  assign chain_wr  = {pipe_wr,  cmd_valid_i & cmd_is_wr_i};

  assign al_idx = IDX_W'(al_o);
  assign rl_idx = IDX_W'(al_o) + IDX_W'(cl_i);
  assign wl_idx = rl_idx - IDX_W'(1);

  al_tap #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tap_al (
    .vld_i(chain_vld), .wr_i(chain_wr), .idx_i(al_idx), .cmd_o(al_cmd));
  al_tap #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tap_rl (
    .vld_i(chain_vld), .wr_i(chain_wr), .idx_i(rl_idx), .cmd_o(rl_cmd));
  al_tap #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tap_wl (
    .vld_i(chain_vld), .wr_i(chain_wr), .idx_i(wl_idx), .cmd_o(wl_cmd));

  assign int_cmd_valid_o = al_cmd.vld;
  assign int_cmd_is_wr_o = al_cmd.vld & al_cmd.is_wr;
  assign rd_data_start_o = rl_cmd.vld & ~rl_cmd.is_wr;
  assign wr_data_start_o = wl_cmd.vld &  wl_cmd.is_wr;

  // a write at its WL tap reaches the RL tap one cycle later
  p_wl_one_before_rl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_cmd.vld && wl_cmd.is_wr && !emr_load_i) |=> (rl_cmd.vld && rl_cmd.is_wr));
  // an internal issue at AL reaches the WL tap after CL-1 more cycles; checked one step on
  p_int_advances_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al_cmd.vld && !emr_load_i && cl_i > CL_W'(1)) |=> pipe_vld[al_idx]);
endmodule

// File: tb/tb_al_sched.sv
module tb_al_sched;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        emr_load_i = 1'b0;
  logic [13:0] emr_i = '0;
  logic [2:0]  cl_i = 3'd2;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_is_wr_i = 1'b0;
  logic [2:0]  al_o;
  logic        cfg_err_o, int_cmd_valid_o, int_cmd_is_wr_o;
  logic        rd_data_start_o, wr_data_start_o;

  al_sched dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, per = 0;
  int m_al = 0;
  logic m_err = 1'b0;
  logic ex_int [64], ex_intw [64], ex_rd [64], ex_wr [64];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s period %0d: got %0d expected %0d", tag, per, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 64; i++) begin
      ex_int[i] = 0; ex_intw[i] = 0; ex_rd[i] = 0; ex_wr[i] = 0;
    end
  endtask

  task automatic step(input logic v, input logic w, input logic ld, input logic [13:0] word);
    int idx;
    @(negedge clk_i);
    cmd_valid_i = v; cmd_is_wr_i = w; emr_load_i = ld; emr_i = word;
    if (v) begin
      ex_int[(per + m_al) % 64] = 1;
      ex_intw[(per + m_al) % 64] = w;
      if (w) ex_wr[(per + m_al + int'(cl_i) - 1) % 64] = 1;
      else   ex_rd[(per + m_al + int'(cl_i)) % 64] = 1;
    end
    #5;
    idx = per % 64;
    chk("R4 int_valid", int'(int_cmd_valid_o), int'(ex_int[idx]));
    if (ex_int[idx]) chk("R4 int_type", int'(int_cmd_is_wr_o), int'(ex_intw[idx]));
    chk("R5 R9 rd_start", int'(rd_data_start_o), int'(ex_rd[idx]));
    chk("R6 R9 wr_start", int'(wr_data_start_o), int'(ex_wr[idx]));
    chk("R2 al", int'(al_o), m_al);
    chk("R3 err", int'(cfg_err_o), int'(m_err));
    ex_int[idx] = 0; ex_intw[idx] = 0; ex_rd[idx] = 0; ex_wr[idx] = 0;
    if (ld) begin
      if (word[5:3] == 3'd7) m_err = 1'b1; // R3
      else m_al = int'(word[5:3]);        // R1: field at bits 5:3
    end
    per++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0);
  endtask

  task automatic load_al(input logic [2:0] code);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    // R1: junk outside bits 5:3
    step(0, 0, 1, {lfsr[7:0], code, lfsr[10:8]});
  endtask

  // R8: reset mid-burst discards pending commands
  task automatic do_reset();
    @(negedge clk_i);
    cmd_valid_i = 0; emr_load_i = 0;
    rst_ni = 0;
    #5;
    chk("R8 al_rst", int'(al_o), 0);
    chk("R8 err_rst", int'(cfg_err_o), 0);
    @(negedge clk_i);
    rst_ni = 1;
    clear_model();
    m_al = 0; m_err = 0;
    per++;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_model();
    #5;
    chk("R8 al_reset", int'(al_o), 0);
    chk("R8 err_reset", int'(cfg_err_o), 0);
    @(negedge clk_i);
    rst_ni = 1;
    for (int cl = 2; cl <= 6; cl++) begin
      cl_i = 3'(cl);
      idle(2);
      for (int code = 0; code < 8; code++) begin
        load_al(3'(code));
        idle(1);
        // R7: a command every cycle, alternating type
        for (int k = 0; k < 10; k++) step(1, 1'(k % 2), 0, '0);
        // R7: paired read-then-write, same start period
        for (int k = 0; k < 6; k++) step(1, 1'(k % 2 == 1), 0, '0);
        for (int k = 0; k < 12; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          step(lfsr[0] & lfsr[3], lfsr[1], 0, '0);
        end
        idle(14);
        if (code == 7) begin
          // R3: flag persists; a valid load still applies
          load_al(3'd2);
          idle(2);
          for (int k = 0; k < 4; k++) step(1, 1'(k % 2), 0, '0);
          do_reset();
          idle(1);
        end
      end
      // R8: reset with commands in flight
      load_al(3'd6);
      for (int k = 0; k < 5; k++) step(1, 1'(k % 2), 0, '0);
      do_reset();
      idle(16);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule